// File: doc/BRIEF.md
# Divergent Branch Lane Mask Stack

This block keeps the active-lane mask for one thread of SIMD instructions that runs if/else code in which lanes disagree. All lanes walk through both sides of a branch. The mask alone decides which lanes write results back. The block never selects instruction addresses.

The sequencer gives one command per cycle:
- **Push**, at a branch: the current mask is saved and the active mask narrows to the lanes whose predicate bit is 1.
- **Flip**, at the else point: the active mask becomes the saved mask with the taken lanes removed.
- **Pop**, at the join point: the saved mask comes back.

Pushes nest up to a parameterized depth. Misuse leaves sticky overflow and underflow flags.

Every result appears on the clock edge after the command. The stack is a small memory with one write port and an asynchronous read of the top entry. This suits distributed RAM on an FPGA.

Top module: `simt_mask_stack`

## Requirements
- R1: While `rst` is high and on the first edge after it, `active_o` is all ones, `empty_o` is 1, and `full_o`, `ovf_o` and `udf_o` are 0.
- R2: A lone push on a non-full stack saves the current mask together with `pred_i`. On the next edge `active_o` becomes the old mask AND `pred_i`, where bit i is lane i and 1 means taken.
- R3: A lone flip on a non-empty stack sets `active_o` to the top saved mask AND NOT the predicate saved with it. The value on `pred_i` during the flip has no effect.
- R4: A lone pop on a non-empty stack restores the top saved mask to `active_o` and removes that entry. Nested push/pop pairs therefore unwind in last-in first-out order.
- R5: `full_o` is 1 exactly when DEPTH entries are held. `empty_o` is 1 exactly when none are held.
- R6: A lone push while full sets `ovf_o`. It leaves the mask and the stack unchanged.
- R7: A lone pop or flip while empty sets `udf_o`. It leaves the mask and the stack unchanged.
- R8: A cycle with two or more commands raised performs none of them and sets no flag.
- R9: Once set, `ovf_o` and `udf_o` stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Divergent branch: save the mask and narrow it to the taken lanes |
| flip_i | input | 1 | Else point: switch to the untaken lanes of the top entry |
| pop_i | input | 1 | Join point: restore the top saved mask |
| pred_i | input | LANES | Taken-path predicate, one bit per lane |
| active_o | output | LANES | Lanes allowed to write back |
| full_o | output | 1 | Stack holds DEPTH entries |
| empty_o | output | 1 | Stack holds no entries |
| ovf_o | output | 1 | Sticky: a push was attempted while full |
| udf_o | output | 1 | Sticky: a pop or flip was attempted while empty |

## Verification
The assertions assume that `rst` is held high from time zero, so every register has a defined value before the first `$past` sample. They assume nothing about the command inputs. Illegal combinations, pushes while full and pops or flips while empty are all defined behaviour, and the bench drives them on purpose. The random stimulus mixes single commands, idle cycles and multi-command cycles with random predicates. Directed sequences fill the stack to the limit, push past it, drain it and pop below it, and flip with a `pred_i` that differs from the stored one. All inputs change only on falling edges.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  // Command accepted for the current cycle
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_FLIP = 2'd2,
    OP_POP  = 2'd3
  } mask_op_e;
endpackage

// File: rtl/mask_stack_store.sv
module mask_stack_store #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wmask,
  input  logic [LANES-1:0] wpred,
  input  logic [AW-1:0]    raddr,
  output logic [LANES-1:0] rmask,
  output logic [LANES-1:0] rpred
);
  // Each entry holds a saved mask and the predicate it was narrowed by.
  // No reset on the memory, so it maps to distributed RAM.
  logic [LANES-1:0] mask_mem [DEPTH];
  logic [LANES-1:0] pred_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mask_mem[waddr] <= wmask;
      pred_mem[waddr] <= wpred;
    end
  end

  assign rmask = mask_mem[raddr];
  assign rpred = pred_mem[raddr];
endmodule

// File: rtl/mask_stack_ctrl.sv
module mask_stack_ctrl
  import simt_mask_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          flip_i,
  input  logic          pop_i,
  output mask_op_e      op_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [1:0]    cmd_n;
  logic          single;
  logic [CW-1:0] top_idx;

  assign cmd_n   = 2'($countones({push_i, flip_i, pop_i}));
  assign single  = (cmd_n == 2'd1);
  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign top_idx = count_o - CW'(1);
  assign wr_addr_o = count_o[AW-1:0];
  assign rd_addr_o = top_idx[AW-1:0];

  always_comb begin
    op_o = OP_NONE;
    if (single) begin
      if (push_i && !full_o)       op_o = OP_PUSH;
      else if (flip_i && !empty_o) op_o = OP_FLIP;
      else if (pop_i && !empty_o)  op_o = OP_POP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      if (op_o == OP_PUSH) count_o <= count_o + CW'(1);
      else if (op_o == OP_POP) count_o <= count_o - CW'(1);
      if (single && push_i && full_o) ovf_o <= 1'b1;
      if (single && (flip_i || pop_i) && empty_o) udf_o <= 1'b1;
    end
  end

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH));
  // R4
  pop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (op_o == OP_POP) |=> (count_o == $past(count_o) - CW'(1)));
  // R8
  multi_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n > 2'd1) |=> ($stable(count_o) && $stable(ovf_o) && $stable(udf_o)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  // R9
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    udf_o |=> udf_o);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (single && push_i && full_o) |=> $stable(count_o));
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             flip_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] active_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  mask_op_e         op;
  logic [CW-1:0]    count;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [LANES-1:0] top_mask, top_pred;

  mask_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_i(push_i), .flip_i(flip_i), .pop_i(pop_i),
    .op_o(op), .count_o(count), .full_o(full_o), .empty_o(empty_o),
    .ovf_o(ovf_o), .udf_o(udf_o), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr)
  );

  mask_stack_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(op == OP_PUSH), .waddr(wr_addr), .wmask(active_o),
    .wpred(pred_i), .raddr(rd_addr), .rmask(top_mask), .rpred(top_pred)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= '1;
    end else begin
      unique case (op)
        OP_PUSH: active_o <= active_o & pred_i;
        OP_FLIP: active_o <= top_mask & ~top_pred;
        OP_POP:  active_o <= top_mask;
        default: active_o <= active_o;
      endcase
    end
  end

  // R2
  push_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH) |=> ((active_o & ~$past(active_o)) == '0));
  // R3
  flip_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FLIP) |=> ((active_o & ~$past(top_mask)) == '0));
  // R6
  ovf_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !flip_i && !pop_i && full_o) |=> $stable(active_o));
  // R7
  udf_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_i && (flip_i ^ pop_i) && empty_o) |=> $stable(active_o));
endmodule

// File: tb/simt_mask_stack_bench.sv
module simt_mask_stack_bench;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             push_i = 1'b0, flip_i = 1'b0, pop_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [LANES-1:0] active_o;
  logic             full_o, empty_o, ovf_o, udf_o;

  int checks = 0;
  int errors = 0;

  logic [LANES-1:0] m_mask [DEPTH];
  logic [LANES-1:0] m_pred [DEPTH];
  logic [LANES-1:0] m_act;
  int               m_cnt;
  logic             m_ovf, m_udf;

  always #2 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_simt_mask_stack (
    .clk(clk), .rst(rst), .push_i(push_i), .flip_i(flip_i), .pop_i(pop_i),
    .pred_i(pred_i), .active_o(active_o), .full_o(full_o), .empty_o(empty_o),
    .ovf_o(ovf_o), .udf_o(udf_o)
  );

  function automatic logic [LANES-1:0] exp_push(logic [LANES-1:0] a, logic [LANES-1:0] p);
    return a & p;
  endfunction

  function automatic logic [LANES-1:0] exp_flip(logic [LANES-1:0] m, logic [LANES-1:0] p);
    return m & ~p;
  endfunction

  task automatic chk(string tag, logic [LANES-1:0] got, logic [LANES-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " active"}, active_o, m_act);
    chk("R5 full", LANES'(full_o), LANES'(m_cnt == DEPTH));
    chk("R5 empty", LANES'(empty_o), LANES'(m_cnt == 0));
    chk("R9 R6 ovf", LANES'(ovf_o), LANES'(m_ovf));
    chk("R9 R7 udf", LANES'(udf_o), LANES'(m_udf));
  endtask

  task automatic model_reset();
    m_act = '1; m_cnt = 0; m_ovf = 1'b0; m_udf = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; push_i = 0; flip_i = 0; pop_i = 0;
    @(posedge clk); @(negedge clk);
    model_reset();
    compare("R1 in-reset");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    compare("R1 after-reset");
  endtask

  // Drive one cycle at a falling edge, then check at the next falling edge
  task automatic step(logic ps, logic fl, logic pp, logic [LANES-1:0] pr);
    string tag;
    int n;
    push_i = ps; flip_i = fl; pop_i = pp; pred_i = pr;
    @(posedge clk); @(negedge clk);
    n = int'(ps) + int'(fl) + int'(pp);
    tag = "idle";
    if (n > 1) tag = "R8";
    else if (ps) begin
      if (m_cnt == DEPTH) begin m_ovf = 1'b1; tag = "R6"; end
      else begin
        m_mask[m_cnt] = m_act; m_pred[m_cnt] = pr;
        m_act = exp_push(m_act, pr); m_cnt++; tag = "R2";
      end
    end else if (fl) begin
      if (m_cnt == 0) begin m_udf = 1'b1; tag = "R7"; end
      else begin m_act = exp_flip(m_mask[m_cnt-1], m_pred[m_cnt-1]); tag = "R3"; end
    end else if (pp) begin
      if (m_cnt == 0) begin m_udf = 1'b1; tag = "R7"; end
      else begin m_cnt--; m_act = m_mask[m_cnt]; tag = "R4"; end
    end
    push_i = 0; flip_i = 0; pop_i = 0;
    compare(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R7: pop and flip on empty
    step(0, 0, 1, '0);
    step(0, 1, 0, '1);
    // R3: flip ignores pred_i and uses the stored predicate
    do_reset();
    step(1, 0, 0, 32'h0000_FFFF);
    step(0, 1, 0, 32'hFFFF_0000);
    step(1, 0, 0, 32'h0000_00F0);
    step(0, 1, 0, 32'h1234_5678);
    step(0, 0, 1, '0);
    step(0, 0, 1, '0);
    // R2: push with an all-zero predicate, then flip gives every saved lane
    step(1, 0, 0, '0);
    step(0, 1, 0, '0);
    step(0, 0, 1, '0);
    // R5 R6: fill, overflow, drain, underflow
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, ~(32'h1 << i));
    step(1, 0, 0, 32'hDEAD_BEEF);
    step(1, 0, 0, '1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, '0);
    step(0, 0, 1, '0);
    // R8: multiple commands at once
    do_reset();
    step(1, 0, 0, 32'hAAAA_AAAA);
    step(1, 1, 0, 32'h5555_5555);
    step(0, 1, 1, '0);
    step(1, 1, 1, '0);
    step(1, 0, 1, '0);

    // Random mix
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      int r;
      logic [LANES-1:0] p;
      if (k % 700 == 699) do_reset();
      r = int'($urandom % 16);
      p = $urandom;
      if (r < 6)       step(1, 0, 0, p);
      else if (r < 9)  step(0, 1, 0, p);
      else if (r < 13) step(0, 0, 1, p);
      else if (r == 13) step(0, 0, 0, p);
      else step(1'($urandom), 1'b1, 1'b1, p);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule